// File: doc/BRIEF.md
# RAID0 Striping Data Splitter

This block joins several storage controllers of equal data width into one wider port, so that software sees one device with the combined capacity and the combined bandwidth. The user side carries command packets and write data on a command channel, and receives acknowledges and read data on a response channel. Every command beat is copied to all controllers with the same sector address and sector count. Each wide write beat is cut into per-controller slices. Read beats from all controllers are merged back into one wide beat.

Beats are accepted with a valid/ready handshake: a beat moves when valid and ready are both high in the same cycle. The port moves in lock-step with the slowest controller. A command beat completes only after every controller has taken it. A response beat is shown to the user only while every controller offers one.

The response status is merged. The error flag is the OR of all controllers' error flags. The packet-boundary and final-packet flags come from controller 0. A read transaction ends with an empty packet that carries the final flag, and this packet passes through like any other beat.

Top module: `raid0_splitter`

## Requirements
- R1: Bits [i*CTRL_DW +: CTRL_DW] of `usr_cmd_data` appear unchanged on slice i of `dev_cmd_data`, the slice that controller i receives.
- R2: The sector address, the sector count, the operation bits (write, read, identify) and the first/end packet flags of the user command are presented unchanged to every controller.
- R3: A user command beat completes (`usr_cmd_valid` and `usr_cmd_ready` both high) in the first cycle by which every controller has accepted that beat, counting acceptances in earlier cycles of the same beat. Each controller accepts each beat exactly once: after controller i accepts, its `dev_cmd_valid` bit stays low until the user beat completes.
- R4: When every controller is ready, a user command beat completes in the same cycle it is presented.
- R5: `usr_rsp_valid` is high only in cycles where all `dev_rsp_valid` bits are high.
- R6: Each `dev_rsp_ready` bit is high exactly when `usr_rsp_ready` is high and all `dev_rsp_valid` bits are high.
- R7: Slice i of `usr_rsp_data` (bits [i*CTRL_DW +: CTRL_DW]) equals `dev_rsp_data` slice i.
- R8: `usr_rsp_err` is the OR of the error flags of all controllers.
- R9: The user response flags for first, end, final, write, read and identify are taken from controller 0. This includes the empty final packet (final=1) that ends a read.
- R10: Reset (active-low `rst_n`) clears all record of partial acceptance. After reset, a presented command beat is offered to every controller, even if some controllers had accepted it before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| usr_cmd_valid | input | 1 | User command beat valid |
| usr_cmd_ready | output | 1 | User command beat accepted by all controllers |
| usr_cmd_first | input | 1 | First beat of packet |
| usr_cmd_end | input | 1 | Last beat of packet |
| usr_cmd_wr | input | 1 | Write operation |
| usr_cmd_rd | input | 1 | Read operation |
| usr_cmd_id | input | 1 | Identify operation |
| usr_cmd_lba | input | 48 | Sector address |
| usr_cmd_cnt | input | 16 | Sector count |
| usr_cmd_data | input | NUM_CTRL*CTRL_DW | Wide write data |
| usr_rsp_valid | output | 1 | Joined response beat valid |
| usr_rsp_ready | input | 1 | User takes the response beat |
| usr_rsp_first | output | 1 | First beat of response packet |
| usr_rsp_end | output | 1 | Last beat of response packet |
| usr_rsp_wr | output | 1 | Response belongs to a write |
| usr_rsp_rd | output | 1 | Response belongs to a read |
| usr_rsp_id | output | 1 | Response belongs to an identify |
| usr_rsp_final | output | 1 | Final packet of the response |
| usr_rsp_err | output | 1 | Any controller reported an error |
| usr_rsp_data | output | NUM_CTRL*CTRL_DW | Wide read data |
| dev_cmd_valid | output | NUM_CTRL | Per-controller command valid |
| dev_cmd_ready | input | NUM_CTRL | Per-controller command ready |
| dev_cmd_first | output | NUM_CTRL | First flag copy per controller |
| dev_cmd_end | output | NUM_CTRL | End flag copy per controller |
| dev_cmd_wr | output | NUM_CTRL | Write bit copy per controller |
| dev_cmd_rd | output | NUM_CTRL | Read bit copy per controller |
| dev_cmd_id | output | NUM_CTRL | Identify bit copy per controller |
| dev_cmd_lba | output | NUM_CTRL*48 | Sector address per controller |
| dev_cmd_cnt | output | NUM_CTRL*16 | Sector count per controller |
| dev_cmd_data | output | NUM_CTRL*CTRL_DW | Write data slice per controller |
| dev_rsp_valid | input | NUM_CTRL | Per-controller response valid |
| dev_rsp_ready | output | NUM_CTRL | Per-controller response ready |
| dev_rsp_first | input | NUM_CTRL | First flag per controller |
| dev_rsp_end | input | NUM_CTRL | End flag per controller |
| dev_rsp_wr | input | NUM_CTRL | Write flag per controller |
| dev_rsp_rd | input | NUM_CTRL | Read flag per controller |
| dev_rsp_id | input | NUM_CTRL | Identify flag per controller |
| dev_rsp_final | input | NUM_CTRL | Final flag per controller |
| dev_rsp_err | input | NUM_CTRL | Error flag per controller |
| dev_rsp_data | input | NUM_CTRL*CTRL_DW | Read data slice per controller |

## Verification
The assertions assume two things about the inputs. First, the user holds the command address steady while a beat waits for acceptance. Second, while all controllers offer a response, they agree on the final and packet-boundary flags; only their error flags may differ. The bench keeps within both assumptions. It drives every command beat unchanged until the port accepts it. Its controller models always raise identical flags and only vary the error bits and the data. The per-controller ready patterns are stretched over several cycles, which exercises partial acceptance and the exactly-once rule.

// File: rtl/raid0_pkg.sv
package raid0_pkg;
   localparam int LBA_W = 48;
   localparam int CNT_W = 16;

   typedef enum logic {
      FORK_COMBINED   = 1'b0,
      FORK_REGISTERED = 1'b1
   } fork_mode_e;
endpackage

// File: rtl/raid0_cmd_fork.sv
module raid0_cmd_fork
   import raid0_pkg::*;
#(
   parameter int         NUM_CTRL = 2,
   parameter fork_mode_e MODE     = FORK_REGISTERED
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                up_valid,
   output logic                up_ready,
   output logic [NUM_CTRL-1:0] dn_valid,
   input  logic [NUM_CTRL-1:0] dn_ready
);
   if (NUM_CTRL < 1) begin : g_bad_n
      $error("raid0_cmd_fork: NUM_CTRL must be at least 1");
   end

   if (MODE == FORK_REGISTERED) begin : g_reg
      // taken_q[i]: controller i already holds the current beat
      logic [NUM_CTRL-1:0] taken_q;
      logic                fire;

      assign fire     = up_valid & up_ready;
      assign up_ready = &(dn_ready | taken_q);
      assign dn_valid = {NUM_CTRL{up_valid}} & ~taken_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            taken_q <= '0;
         end else if (fire) begin
            taken_q <= '0;
         end else begin
            taken_q <= taken_q | (dn_valid & dn_ready);
         end
      end
   end else begin : g_comb
      logic unused_clk_rst;
      assign unused_clk_rst = ^{clk, rst_n};
      assign up_ready       = &dn_ready;
      for (genvar i = 0; i < NUM_CTRL; i++) begin : g_br
         localparam logic [NUM_CTRL-1:0] SELF = NUM_CTRL'(1) << i;
         assign dn_valid[i] = up_valid & (&(dn_ready | SELF));
      end
   end
endmodule

// File: rtl/raid0_rsp_join.sv
module raid0_rsp_join #(
   parameter int NUM_CTRL = 2,
   parameter int CTRL_DW  = 32,
   localparam int WIDE_W  = NUM_CTRL * CTRL_DW
) (
   input  logic [NUM_CTRL-1:0] dn_valid,
   output logic [NUM_CTRL-1:0] dn_ready,
   input  logic [WIDE_W-1:0]   dn_data,
   input  logic [NUM_CTRL-1:0] dn_first,
   input  logic [NUM_CTRL-1:0] dn_end,
   input  logic [NUM_CTRL-1:0] dn_wr,
   input  logic [NUM_CTRL-1:0] dn_rd,
   input  logic [NUM_CTRL-1:0] dn_id,
   input  logic [NUM_CTRL-1:0] dn_final,
   input  logic [NUM_CTRL-1:0] dn_err,
   output logic                up_valid,
   input  logic                up_ready,
   output logic [WIDE_W-1:0]   up_data,
   output logic                up_first,
   output logic                up_end,
   output logic                up_wr,
   output logic                up_rd,
   output logic                up_id,
   output logic                up_final,
   output logic                up_err
);
   if (CTRL_DW < 1) begin : g_bad_dw
      $error("raid0_rsp_join: CTRL_DW must be at least 1");
   end

   logic all_valid;
   assign all_valid = &dn_valid;
   assign up_valid  = all_valid;
   assign dn_ready  = {NUM_CTRL{all_valid & up_ready}};

   for (genvar i = 0; i < NUM_CTRL; i++) begin : g_slice
      assign up_data[i*CTRL_DW +: CTRL_DW] = dn_data[i*CTRL_DW +: CTRL_DW];
   end

   assign up_first = dn_first[0];
   assign up_end   = dn_end[0];
   assign up_wr    = dn_wr[0];
   assign up_rd    = dn_rd[0];
   assign up_id    = dn_id[0];
   assign up_final = dn_final[0];
   assign up_err   = |dn_err;

   if (NUM_CTRL > 1) begin : g_others
      logic unused_flags;
      assign unused_flags = ^{dn_first[NUM_CTRL-1:1], dn_end[NUM_CTRL-1:1],
                              dn_wr[NUM_CTRL-1:1], dn_rd[NUM_CTRL-1:1],
                              dn_id[NUM_CTRL-1:1], dn_final[NUM_CTRL-1:1]};
   end
endmodule

// File: rtl/raid0_splitter.sv
module raid0_splitter
   import raid0_pkg::*;
#(
   parameter int         NUM_CTRL  = 2,
   parameter int         CTRL_DW   = 32,
   parameter fork_mode_e FORK_MODE = FORK_REGISTERED,
   localparam int        WIDE_W    = NUM_CTRL * CTRL_DW
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      usr_cmd_valid,
   output logic                      usr_cmd_ready,
   input  logic                      usr_cmd_first,
   input  logic                      usr_cmd_end,
   input  logic                      usr_cmd_wr,
   input  logic                      usr_cmd_rd,
   input  logic                      usr_cmd_id,
   input  logic [LBA_W-1:0]          usr_cmd_lba,
   input  logic [CNT_W-1:0]          usr_cmd_cnt,
   input  logic [WIDE_W-1:0]         usr_cmd_data,
   output logic                      usr_rsp_valid,
   input  logic                      usr_rsp_ready,
   output logic                      usr_rsp_first,
   output logic                      usr_rsp_end,
   output logic                      usr_rsp_wr,
   output logic                      usr_rsp_rd,
   output logic                      usr_rsp_id,
   output logic                      usr_rsp_final,
   output logic                      usr_rsp_err,
   output logic [WIDE_W-1:0]         usr_rsp_data,
   output logic [NUM_CTRL-1:0]       dev_cmd_valid,
   input  logic [NUM_CTRL-1:0]       dev_cmd_ready,
   output logic [NUM_CTRL-1:0]       dev_cmd_first,
   output logic [NUM_CTRL-1:0]       dev_cmd_end,
   output logic [NUM_CTRL-1:0]       dev_cmd_wr,
   output logic [NUM_CTRL-1:0]       dev_cmd_rd,
   output logic [NUM_CTRL-1:0]       dev_cmd_id,
   output logic [NUM_CTRL*LBA_W-1:0] dev_cmd_lba,
   output logic [NUM_CTRL*CNT_W-1:0] dev_cmd_cnt,
   output logic [WIDE_W-1:0]         dev_cmd_data,
   input  logic [NUM_CTRL-1:0]       dev_rsp_valid,
   output logic [NUM_CTRL-1:0]       dev_rsp_ready,
   input  logic [NUM_CTRL-1:0]       dev_rsp_first,
   input  logic [NUM_CTRL-1:0]       dev_rsp_end,
   input  logic [NUM_CTRL-1:0]       dev_rsp_wr,
   input  logic [NUM_CTRL-1:0]       dev_rsp_rd,
   input  logic [NUM_CTRL-1:0]       dev_rsp_id,
   input  logic [NUM_CTRL-1:0]       dev_rsp_final,
   input  logic [NUM_CTRL-1:0]       dev_rsp_err,
   input  logic [WIDE_W-1:0]         dev_rsp_data
);
   if (NUM_CTRL < 1 || NUM_CTRL > 64) begin : g_bad_n
      $error("raid0_splitter: NUM_CTRL out of range 1..64");
   end
   if (CTRL_DW < 1) begin : g_bad_dw
      $error("raid0_splitter: CTRL_DW must be at least 1");
   end

   // command side: handshake fork plus field fan-out
   raid0_cmd_fork #(
      .NUM_CTRL (NUM_CTRL),
      .MODE     (FORK_MODE)
   ) i_fork (
      .clk      (clk),
      .rst_n    (rst_n),
      .up_valid (usr_cmd_valid),
      .up_ready (usr_cmd_ready),
      .dn_valid (dev_cmd_valid),
      .dn_ready (dev_cmd_ready)
   );

   for (genvar i = 0; i < NUM_CTRL; i++) begin : g_fan
      assign dev_cmd_first[i]                = usr_cmd_first;
      assign dev_cmd_end[i]                  = usr_cmd_end;
      assign dev_cmd_wr[i]                   = usr_cmd_wr;
      assign dev_cmd_rd[i]                   = usr_cmd_rd;
      assign dev_cmd_id[i]                   = usr_cmd_id;
      assign dev_cmd_lba[i*LBA_W +: LBA_W]   = usr_cmd_lba;
      assign dev_cmd_cnt[i*CNT_W +: CNT_W]   = usr_cmd_cnt;
      assign dev_cmd_data[i*CTRL_DW +: CTRL_DW] = usr_cmd_data[i*CTRL_DW +: CTRL_DW];
   end

   // response side: join and status merge
   raid0_rsp_join #(
      .NUM_CTRL (NUM_CTRL),
      .CTRL_DW  (CTRL_DW)
   ) i_join (
      .dn_valid (dev_rsp_valid),
      .dn_ready (dev_rsp_ready),
      .dn_data  (dev_rsp_data),
      .dn_first (dev_rsp_first),
      .dn_end   (dev_rsp_end),
      .dn_wr    (dev_rsp_wr),
      .dn_rd    (dev_rsp_rd),
      .dn_id    (dev_rsp_id),
      .dn_final (dev_rsp_final),
      .dn_err   (dev_rsp_err),
      .up_valid (usr_rsp_valid),
      .up_ready (usr_rsp_ready),
      .up_data  (usr_rsp_data),
      .up_first (usr_rsp_first),
      .up_end   (usr_rsp_end),
      .up_wr    (usr_rsp_wr),
      .up_rd    (usr_rsp_rd),
      .up_id    (usr_rsp_id),
      .up_final (usr_rsp_final),
      .up_err   (usr_rsp_err)
   );
endmodule

// File: rtl/raid0_splitter_chk.sv
module raid0_splitter_chk
   import raid0_pkg::*;
#(
   parameter int         NUM_CTRL  = 2,
   parameter fork_mode_e FORK_MODE = FORK_REGISTERED
) (
   input logic                clk,
   input logic                rst_n,
   input logic                usr_cmd_valid,
   input logic                usr_cmd_ready,
   input logic [LBA_W-1:0]    usr_cmd_lba,
   input logic                usr_rsp_valid,
   input logic                usr_rsp_ready,
   input logic                usr_rsp_err,
   input logic [NUM_CTRL-1:0] dev_cmd_valid,
   input logic [NUM_CTRL-1:0] dev_cmd_ready,
   input logic [NUM_CTRL-1:0] dev_rsp_valid,
   input logic [NUM_CTRL-1:0] dev_rsp_ready,
   input logic [NUM_CTRL-1:0] dev_rsp_final,
   input logic [NUM_CTRL-1:0] dev_rsp_err
);
   // input assumption: a waiting beat keeps its address (R2)
   p_cmd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      usr_cmd_valid && !usr_cmd_ready |=> $stable(usr_cmd_lba));

   // all controllers ready means the beat goes at once (R4)
   p_all_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
      usr_cmd_valid && (&dev_cmd_ready) |-> usr_cmd_ready);

   if (FORK_MODE == FORK_REGISTERED) begin : g_once
      for (genvar i = 0; i < NUM_CTRL; i++) begin : g_c
         // a controller that took the beat is not offered it again (R3)
         p_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
            dev_cmd_valid[i] && dev_cmd_ready[i] && !usr_cmd_ready
            |=> !dev_cmd_valid[i]);
      end
   end

   p_rsp_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
      usr_rsp_valid |-> (&dev_rsp_valid));

   p_rsp_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|dev_rsp_ready) |-> usr_rsp_ready && (&dev_rsp_valid));

   p_rsp_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
      usr_rsp_valid && usr_rsp_ready |-> (&dev_rsp_ready));

   p_rsp_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
      usr_rsp_valid |-> (usr_rsp_err == (|dev_rsp_err)));

   // input assumption: controllers agree on the final flag (R9)
   p_final_agree_r9: assert property (@(posedge clk) disable iff (!rst_n)
      usr_rsp_valid |-> (dev_rsp_final == {NUM_CTRL{dev_rsp_final[0]}}));
endmodule

bind raid0_splitter raid0_splitter_chk #(
   .NUM_CTRL  (NUM_CTRL),
   .FORK_MODE (FORK_MODE)
) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .usr_cmd_valid (usr_cmd_valid),
   .usr_cmd_ready (usr_cmd_ready),
   .usr_cmd_lba   (usr_cmd_lba),
   .usr_rsp_valid (usr_rsp_valid),
   .usr_rsp_ready (usr_rsp_ready),
   .usr_rsp_err   (usr_rsp_err),
   .dev_cmd_valid (dev_cmd_valid),
   .dev_cmd_ready (dev_cmd_ready),
   .dev_rsp_valid (dev_rsp_valid),
   .dev_rsp_ready (dev_rsp_ready),
   .dev_rsp_final (dev_rsp_final),
   .dev_rsp_err   (dev_rsp_err)
);

// File: tb/test_raid0_splitter.sv
module test_raid0_splitter;
   localparam int N  = 2;
   localparam int DW = 32;
   localparam int WW = N * DW;

   typedef struct packed {
      logic [63:0] data;
      logic [47:0] lba;
      logic [15:0] cnt;
      logic [2:0]  op;    // {wr, rd, id}
      logic [7:0]  pat0;  // ready of controller 0, bit k = cycle k
      logic [7:0]  pat1;  // ready of controller 1
   } vec_t;

   localparam vec_t VEC [0:5] = '{
      '{64'h1111_2222_3333_4444, 48'h0000_0000_0010, 16'd1, 3'b100, 8'h01, 8'h01},
      '{64'hDEAD_BEEF_0BAD_F00D, 48'hFFFF_FFFF_FFF0, 16'd8, 3'b100, 8'h02, 8'h01},
      '{64'h0123_4567_89AB_CDEF, 48'h1234_5678_9ABC, 16'hFFFF, 3'b010, 8'h01, 8'h08},
      '{64'hA5A5_5A5A_FFFF_0000, 48'h0000_0000_0000, 16'd0, 3'b001, 8'h04, 8'h04},
      '{64'h8000_0001_7FFF_FFFE, 48'h8000_0000_0001, 16'd3, 3'b100, 8'h06, 8'h03},
      '{64'hCAFE_0000_0000_CAFE, 48'h0000_0BAD_0000, 16'd2, 3'b100, 8'h10, 8'h80}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          usr_cmd_valid = 0, usr_cmd_first = 0, usr_cmd_end = 0;
   logic          usr_cmd_wr = 0, usr_cmd_rd = 0, usr_cmd_id = 0;
   logic [47:0]   usr_cmd_lba = '0;
   logic [15:0]   usr_cmd_cnt = '0;
   logic [WW-1:0] usr_cmd_data = '0;
   logic          usr_cmd_ready;
   logic          usr_rsp_ready = 0;
   logic          usr_rsp_valid, usr_rsp_first, usr_rsp_end, usr_rsp_wr;
   logic          usr_rsp_rd, usr_rsp_id, usr_rsp_final, usr_rsp_err;
   logic [WW-1:0] usr_rsp_data;
   logic [N-1:0]  dev_cmd_valid, dev_cmd_first, dev_cmd_end;
   logic [N-1:0]  dev_cmd_wr, dev_cmd_rd, dev_cmd_id;
   logic [N-1:0]  dev_cmd_ready = '0;
   logic [N*48-1:0] dev_cmd_lba;
   logic [N*16-1:0] dev_cmd_cnt;
   logic [WW-1:0] dev_cmd_data;
   logic [N-1:0]  dev_rsp_valid = '0, dev_rsp_first = '0, dev_rsp_end = '0;
   logic [N-1:0]  dev_rsp_wr = '0, dev_rsp_rd = '0, dev_rsp_id = '0;
   logic [N-1:0]  dev_rsp_final = '0, dev_rsp_err = '0;
   logic [N-1:0]  dev_rsp_ready;
   logic [WW-1:0] dev_rsp_data = '0;

   raid0_splitter #(.NUM_CTRL(N), .CTRL_DW(DW)) i_raid0_splitter (.*);

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic int first_set(input logic [7:0] p);
      for (int k = 0; k < 8; k++) if (p[k]) return k;
      return 99;
   endfunction

   task automatic send_beat(input vec_t v);
      int exp_k, k;
      int acc[N];
      bit done;
      exp_k = (first_set(v.pat0) > first_set(v.pat1)) ? first_set(v.pat0)
                                                       : first_set(v.pat1);
      for (int i = 0; i < N; i++) acc[i] = 0;
      @(negedge clk);
      usr_cmd_valid = 1; usr_cmd_first = 1; usr_cmd_end = 1;
      {usr_cmd_wr, usr_cmd_rd, usr_cmd_id} = v.op;
      usr_cmd_lba = v.lba; usr_cmd_cnt = v.cnt; usr_cmd_data = v.data;
      done = 0; k = 0;
      while (!done && k < 8) begin
         dev_cmd_ready = {v.pat1[k], v.pat0[k]};
         #1;
         for (int i = 0; i < N; i++) begin
            if (dev_cmd_valid[i] && dev_cmd_ready[i]) begin
               acc[i]++;
               chk(dev_cmd_data[i*DW +: DW] == v.data[i*DW +: DW], "R1 slice",
                   64'(dev_cmd_data[i*DW +: DW]), 64'(v.data[i*DW +: DW]));
               chk(dev_cmd_lba[i*48 +: 48] == v.lba && dev_cmd_cnt[i*16 +: 16] == v.cnt,
                   "R2 lba/cnt", 64'(dev_cmd_lba[i*48 +: 48]), 64'(v.lba));
               chk({dev_cmd_wr[i], dev_cmd_rd[i], dev_cmd_id[i], dev_cmd_first[i],
                    dev_cmd_end[i]} == {v.op, 2'b11}, "R2 flags",
                   64'({dev_cmd_wr[i], dev_cmd_rd[i], dev_cmd_id[i]}), 64'(v.op));
            end
         end
         if (usr_cmd_ready) begin
            done = 1;
            chk(k == exp_k, "R3 completion cycle", 64'(k), 64'(exp_k));
         end
         @(negedge clk);
         k++;
      end
      chk(done, "R3 beat completed", 64'(done), 64'd1);
      for (int i = 0; i < N; i++)
         chk(acc[i] == 1, "R3 exactly-once", 64'(acc[i]), 64'd1);
      usr_cmd_valid = 0; dev_cmd_ready = '0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      // reset state (R10)
      repeat (3) @(negedge clk);
      #1;
      chk(dev_cmd_valid == '0, "R10 reset cmd valid", 64'(dev_cmd_valid), 64'd0);
      chk(usr_rsp_valid == 0, "R5 reset rsp valid", 64'(usr_rsp_valid), 64'd0);
      @(negedge clk);
      rst_n = 1;

      // R4: all ready, single cycle
      @(negedge clk);
      usr_cmd_valid = 1; dev_cmd_ready = 2'b11; #1;
      chk(usr_cmd_ready == 1, "R4 same-cycle accept", 64'(usr_cmd_ready), 64'd1);
      chk(dev_cmd_valid == 2'b11, "R4 both offered", 64'(dev_cmd_valid), 64'd3);
      @(negedge clk);
      usr_cmd_valid = 0; dev_cmd_ready = '0;

      // table walk: R1 R2 R3 R4
      foreach (VEC[j]) send_beat(VEC[j]);

      // R10: partial acceptance cleared by reset
      @(negedge clk);
      usr_cmd_valid = 1; dev_cmd_ready = 2'b01;
      @(negedge clk);
      dev_cmd_ready = 2'b00; #1;
      chk(dev_cmd_valid == 2'b10, "R3 taken branch drops", 64'(dev_cmd_valid), 64'd2);
      rst_n = 0;
      @(negedge clk);
      rst_n = 1;
      @(negedge clk); #1;
      chk(dev_cmd_valid == 2'b11, "R10 offered to all after reset",
          64'(dev_cmd_valid), 64'd3);
      usr_cmd_valid = 0;

      // responses: R5 R6 only one controller valid
      @(negedge clk);
      dev_rsp_valid = 2'b01; usr_rsp_ready = 1;
      dev_rsp_data = 64'h1;
      #1;
      chk(usr_rsp_valid == 0, "R5 partial valid", 64'(usr_rsp_valid), 64'd0);
      chk(dev_rsp_ready == 2'b00, "R6 no ack on partial", 64'(dev_rsp_ready), 64'd0);
      @(negedge clk);
      dev_rsp_valid = 2'b11; dev_rsp_rd = 2'b11; dev_rsp_first = 2'b11;
      dev_rsp_data = 64'h89AB_CDEF_0123_4567;
      #1;
      chk(usr_rsp_valid == 1, "R5 all valid", 64'(usr_rsp_valid), 64'd1);
      chk(dev_rsp_ready == 2'b11, "R6 ack all", 64'(dev_rsp_ready), 64'd3);
      chk(usr_rsp_data == 64'h89AB_CDEF_0123_4567, "R7 joined data",
          usr_rsp_data, 64'h89AB_CDEF_0123_4567);
      chk({usr_rsp_rd, usr_rsp_first, usr_rsp_final} == 3'b110, "R9 flags",
          64'({usr_rsp_rd, usr_rsp_first, usr_rsp_final}), 64'h6);
      @(negedge clk);
      usr_rsp_ready = 0; #1;
      chk(dev_rsp_ready == 2'b00, "R6 user stalls", 64'(dev_rsp_ready), 64'd0);

      // R8 error merge, all four combinations
      usr_rsp_ready = 1;
      for (int e = 0; e < 4; e++) begin
         @(negedge clk);
         dev_rsp_err = 2'(e); #1;
         chk(usr_rsp_err == (e != 0), "R8 error OR", 64'(usr_rsp_err), 64'(e != 0));
      end
      dev_rsp_err = '0;

      // R9: empty final packet ending a read
      @(negedge clk);
      dev_rsp_first = 2'b11; dev_rsp_end = 2'b11; dev_rsp_final = 2'b11;
      dev_rsp_data = '0; #1;
      chk({usr_rsp_valid, usr_rsp_final, usr_rsp_end, usr_rsp_rd} == 4'hF,
          "R9 final packet", 64'({usr_rsp_valid, usr_rsp_final, usr_rsp_end, usr_rsp_rd}),
          64'hF);
      @(negedge clk);
      dev_rsp_valid = '0; dev_rsp_final = '0; usr_rsp_ready = 0;
      @(negedge clk);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule